// File: doc/BRIEF.md
# Multi-Slot Compare Alarm Scheduler

The block keeps a small bank of alarm slots, each holding a target count and an arm bit, and shares one compare register among them. The free-running count comes in from outside. Whenever software-side logic arms or disarms a slot and asks for a reschedule, or whenever a batch of alarms fires, a scan walks the slots one per clock. It picks the armed target that lies nearest ahead of a reference placed a few ticks behind the present count. Differences are taken modulo 2^CW, so a counter wrap is harmless and an alarm that only just slipped past can still be caught.

The chosen target is then loaded into the compare register. If that target is too close to the present count, the block places the compare a fixed lead ahead instead. When the count equals the compare value, every armed slot whose target lies within a tolerance window behind the count fires. Each such slot is disarmed and raises a one-cycle bit on `fire`, and a new scan follows by itself.

Commands arrive on a valid/ready channel. `cmd_ready` is high except during the single cycle in which a compare match is serviced; a command is taken on a rising edge where both `cmd_valid` and `cmd_ready` are high. A sender must hold the command stable while ready is low.

Top module: `cmp_alarm_sched`

## Requirements
- R1: After reset, `cmp_en` is 0, `fire` is 0, `busy` is 0, `cmd_ready` is 1 and no slot is armed.
- R2: Operation code 0 (arm) writes the slot's target, arms it and starts a reschedule; once `busy` falls, `cmp_val` holds the armed target with the smallest (target − (now − 4)) mod 2^32, and `cmp_en` is 1.
- R3: Distances are taken modulo 2^32, so with the count just below the wrap, a target just past the wrap is chosen ahead of a target far behind the count.
- R4: A target up to 4 ticks behind the count can still be chosen; a target 5 or more ticks behind counts as nearly a full wrap away.
- R5: When a newly chosen target is nearer the reference than now + 4, the compare is loaded with now + 4; otherwise with the target itself.
- R6: When the winning target equals the value already scheduled, the compare register is left untouched, with no lead clamp applied.
- R7: Operation code 2 (disarm) clears the slot's arm bit and reschedules; with no slot armed, `cmp_en` becomes 0.
- R8: When `cmp_en` is 1 and the count equals `cmp_val`, exactly the armed slots with (now − target) mod 2^32 below 16 pulse their `fire` bit for one cycle and are disarmed, then a reschedule runs.
- R9: Operation codes 1 (quiet arm) and 3 (quiet disarm) update the slot without a reschedule; `busy`, `cmp_val` and `cmp_en` keep their values.
- R10: A command whose slot index is 8 or more changes no slot and starts no reschedule.
- R11: Commands accepted while a scan runs are applied, and a further scan follows so the final compare reflects them.
- R12: `cmd_ready` is low for exactly one cycle per compare match, the cycle in which the match is serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_cnt | input | CW | Present value of the free-running count |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 arm, 1 quiet arm, 2 disarm, 3 quiet disarm |
| cmd_idx | input | IW | Slot index; values of N_SLOTS or more are dropped |
| cmd_tgt | input | CW | Target count for arm operations |
| cmp_val | output | CW | Compare value in force |
| cmp_en | output | 1 | Compare is active |
| fire | output | N_SLOTS | One-cycle pulse per slot that fired |
| busy | output | 1 | Reschedule pending or running |

## Verification
The bench builds the block with its defaults: eight slots, a 32-bit count, a look-back and lead of 4 and a tolerance of 16. The bench drives the count directly rather than letting it run, so it can place the count right beside the wrap and hold it still across a scan. This puts the modulo distance, the look-back edge at 4 versus 5 ticks, and the tolerance edge at 15 versus 16 ticks within reach in a few dozen cycles. It can also jump the count onto the compare value to trigger a batch fire in a chosen cycle.

// File: rtl/alarm_sched_pkg.sv
package alarm_sched_pkg;
  typedef enum logic [1:0] {
    OP_ARM          = 2'd0,
    OP_ARM_QUIET    = 2'd1,
    OP_DISARM       = 2'd2,
    OP_DISARM_QUIET = 2'd3
  } alarm_op_e;

  typedef enum logic [1:0] {
    SEEK_IDLE  = 2'd0,
    SEEK_SCAN  = 2'd1,
    SEEK_APPLY = 2'd2
  } seek_state_e;
endpackage

// File: rtl/alarm_slot_bank.sv
module alarm_slot_bank #(
  parameter int N_SLOTS = 8,
  parameter int CW      = 32,
  parameter int TOL     = 16,
  localparam int IW     = $clog2(N_SLOTS) + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IW-1:0]                wr_idx,
  input  logic                         wr_arm,
  input  logic [CW-1:0]                wr_tgt,
  input  logic [CW-1:0]                now,
  input  logic                         svc,
  output logic [N_SLOTS-1:0][CW-1:0]   tgt_q,
  output logic [N_SLOTS-1:0]           arm_q,
  output logic [N_SLOTS-1:0]           fire_q
);
  logic [N_SLOTS-1:0] due;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic [CW-1:0] behind;
    logic          hit;
    assign behind = now - tgt_q[i];
    assign due[i] = arm_q[i] && (behind < CW'(TOL));
    assign hit    = wr_en && (wr_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tgt_q[i] <= '0;
        arm_q[i] <= 1'b0;
      end else if (svc && due[i]) begin
        arm_q[i] <= 1'b0;
      end else if (hit) begin
        arm_q[i] <= wr_arm;
        if (wr_arm) tgt_q[i] <= wr_tgt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fire_q <= '0;
    else        fire_q <= svc ? due : '0;
  end
endmodule

// File: rtl/alarm_seek.sv
module alarm_seek
  import alarm_sched_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int CW      = 32,
  parameter int GRACE   = 4,
  localparam int SW     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [CW-1:0]              now,
  input  logic [N_SLOTS-1:0][CW-1:0] tgt,
  input  logic [N_SLOTS-1:0]         arm,
  output logic [CW-1:0]              cmp_val,
  output logic                       cmp_en,
  output logic                       busy
);
  seek_state_e   state;
  logic          pend;
  logic [SW-1:0] idx;
  logic [CW-1:0] now_s, min_d, best, sched;
  logic          found;
  logic [CW-1:0] ref_c, dist_c, early_c, pick_c;

  always_comb begin
    ref_c   = now_s - CW'(GRACE);
    dist_c  = tgt[idx] - ref_c;
    early_c = now_s + CW'(GRACE);
    pick_c  = ((early_c - ref_c) > (best - ref_c)) ? early_c : best;
  end

  assign busy = (state != SEEK_IDLE) || pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEEK_IDLE;
      pend    <= 1'b0;
      idx     <= '0;
      now_s   <= '0;
      min_d   <= '1;
      best    <= '0;
      found   <= 1'b0;
      sched   <= '0;
      cmp_val <= '0;
      cmp_en  <= 1'b0;
    end else begin
      if (state == SEEK_IDLE && (pend || start)) pend <= 1'b0;
      else if (start)                            pend <= 1'b1;

      unique case (state)
        SEEK_IDLE: if (pend || start) begin
          state <= SEEK_SCAN;
          idx   <= '0;
          now_s <= now;
          min_d <= '1;
          found <= 1'b0;
        end
        SEEK_SCAN: begin
          if (arm[idx] && dist_c <= min_d) begin
            min_d <= dist_c;
            best  <= tgt[idx];
            found <= 1'b1;
          end
          if (idx == SW'(N_SLOTS - 1)) state <= SEEK_APPLY;
          else                         idx   <= idx + SW'(1);
        end
        SEEK_APPLY: begin
          state <= SEEK_IDLE;
          if (found) begin
            if (best != sched) begin
              cmp_val <= pick_c;
              sched   <= pick_c;
              cmp_en  <= 1'b1;
            end
          end else begin
            sched  <= ref_c - CW'(GRACE);
            cmp_en <= 1'b0;
          end
        end
        default: state <= SEEK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_en,
  input  logic [CW-1:0] cmp_val,
  input  logic [CW-1:0] now,
  output logic          svc
);
  logic eq, eq_q;
  assign eq  = cmp_en && (now == cmp_val);
  assign svc = eq && !eq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end
endmodule

// File: rtl/cmp_alarm_sched.sv
module cmp_alarm_sched
  import alarm_sched_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int CW      = 32,
  parameter int GRACE   = 4,
  parameter int TOL     = 16,
  localparam int IW     = $clog2(N_SLOTS) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      now_cnt,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [IW-1:0]      cmd_idx,
  input  logic [CW-1:0]      cmd_tgt,
  output logic [CW-1:0]      cmp_val,
  output logic               cmp_en,
  output logic [N_SLOTS-1:0] fire,
  output logic               busy
);
  logic                       svc, take, wr_en, wr_arm, resched;
  logic [N_SLOTS-1:0][CW-1:0] tgt_q;
  logic [N_SLOTS-1:0]         arm_q;
  alarm_op_e                  op;

  assign op        = alarm_op_e'(cmd_op);
  assign cmd_ready = !svc;
  assign take      = cmd_valid && cmd_ready;
  assign wr_en     = take && (cmd_idx < IW'(N_SLOTS));
  assign wr_arm    = (op == OP_ARM) || (op == OP_ARM_QUIET);
  assign resched   = (wr_en && ((op == OP_ARM) || (op == OP_DISARM))) || svc;

  alarm_slot_bank #(.N_SLOTS(N_SLOTS), .CW(CW), .TOL(TOL)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(cmd_idx),
    .wr_arm(wr_arm), .wr_tgt(cmd_tgt), .now(now_cnt), .svc(svc),
    .tgt_q(tgt_q), .arm_q(arm_q), .fire_q(fire)
  );

  alarm_seek #(.N_SLOTS(N_SLOTS), .CW(CW), .GRACE(GRACE)) seek_i (
    .clk(clk), .rst_n(rst_n), .start(resched), .now(now_cnt),
    .tgt(tgt_q), .arm(arm_q), .cmp_val(cmp_val), .cmp_en(cmp_en),
    .busy(busy)
  );

  alarm_match #(.CW(CW)) match_i (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .cmp_val(cmp_val),
    .now(now_cnt), .svc(svc)
  );
endmodule

// File: rtl/alarm_sched_chk.sv
module alarm_sched_chk #(
  parameter int N_SLOTS = 8,
  parameter int CW      = 32,
  localparam int IW     = $clog2(N_SLOTS) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CW-1:0]      now_cnt,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [1:0]         cmd_op,
  input logic [IW-1:0]      cmd_idx,
  input logic [CW-1:0]      cmp_val,
  input logic               cmp_en,
  input logic [N_SLOTS-1:0] fire,
  input logic               busy
);
  AST_FIRE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != '0) |-> $past(cmp_en && (now_cnt == cmp_val))); // R8
  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != '0) |=> (fire == '0)); // R8
  AST_FIRE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != '0) |-> $past(!cmd_ready)); // R12
  AST_ARM_STARTS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_idx < IW'(N_SLOTS)) && !cmd_op[0]) |=> busy); // R2
  AST_IDLE_HOLDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> ($stable(cmp_val) && $stable(cmp_en))); // R9
  AST_BAD_IDX_NO_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_idx >= IW'(N_SLOTS)) && !busy) |=> !busy); // R10
endmodule

bind cmp_alarm_sched alarm_sched_chk #(.N_SLOTS(N_SLOTS), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .now_cnt(now_cnt), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
  .cmp_val(cmp_val), .cmp_en(cmp_en), .fire(fire), .busy(busy)
);

// File: tb/cmp_alarm_sched_tb_top.sv
module cmp_alarm_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int CW = 32;
  localparam int IW = $clog2(N) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] now_cnt = '0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [IW-1:0] cmd_idx = '0;
  logic [CW-1:0] cmd_tgt = '0;
  logic [CW-1:0] cmp_val;
  logic          cmp_en;
  logic [N-1:0]  fire;
  logic          busy;

  int errs = 0;
  int checks = 0;
  logic [N-1:0] fire_seen = '0;
  int ready_low = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_alarm_sched dut_i (
    .clk(clk), .rst_n(rst_n), .now_cnt(now_cnt), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .cmd_tgt(cmd_tgt), .cmp_val(cmp_val), .cmp_en(cmp_en),
    .fire(fire), .busy(busy)
  );

  always @(negedge clk) begin
    fire_seen <= fire_seen | fire;
    if (rst_n && !cmd_ready) ready_low <= ready_low + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fire_seen = '0;
    ready_low = 0;
  endtask

  task automatic set_now(input logic [CW-1:0] v);
    @(negedge clk);
    now_cnt = v;
  endtask

  task automatic send(input logic [1:0] op, input logic [IW-1:0] idx, input logic [CW-1:0] tgt);
    @(negedge clk);
    cmd_op = op; cmd_idx = idx; cmd_tgt = tgt; cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(cmp_en == 1'b0, "R1 cmp_en", cmp_en, 0);
    chk(fire == '0, "R1 fire", fire, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
  endtask

  task automatic t_nearest_and_quiet();
    do_reset();
    set_now(1000);
    send(2'd1, 2, 1500);
    send(2'd1, 5, 1200);
    send(2'd0, 7, 3000);
    wait_idle();
    chk(cmp_val == 1200 && cmp_en, "R2 nearest", cmp_val, 1200);
    send(2'd1, 0, 1100);
    @(negedge clk);
    chk(!busy, "R9 quiet no busy", busy, 0);
    chk(cmp_val == 1200, "R9 quiet cmp held", cmp_val, 1200);
    send(2'd2, 7, 0);
    wait_idle();
    chk(cmp_val == 1100, "R9 quiet slot used later", cmp_val, 1100);
  endtask

  task automatic t_wrap();
    do_reset();
    set_now(32'hFFFF_FFF0);
    send(2'd1, 3, 32'hFFFF_FF00);
    send(2'd0, 1, 32'h0000_0010);
    wait_idle();
    chk(cmp_val == 32'h10, "R3 wrap", cmp_val, 32'h10);
  endtask

  task automatic t_lookback();
    do_reset();
    set_now(5000);
    send(2'd1, 1, 5100);
    send(2'd0, 0, 4998);
    wait_idle();
    chk(cmp_val == 5004, "R4 passed by 2 chosen", cmp_val, 5004);
    do_reset();
    set_now(5000);
    send(2'd1, 1, 5100);
    send(2'd0, 0, 4995);
    wait_idle();
    chk(cmp_val == 5100, "R4 passed by 5 skipped", cmp_val, 5100);
  endtask

  task automatic t_clamp();
    do_reset();
    set_now(100);
    send(2'd0, 0, 101);
    wait_idle();
    chk(cmp_val == 104, "R5 clamp", cmp_val, 104);
    do_reset();
    set_now(100);
    send(2'd0, 0, 106);
    wait_idle();
    chk(cmp_val == 106, "R5 no clamp", cmp_val, 106);
  endtask

  task automatic t_same();
    do_reset();
    set_now(100);
    send(2'd0, 0, 110);
    wait_idle();
    set_now(108);
    send(2'd0, 1, 500);
    wait_idle();
    chk(cmp_val == 110, "R6 same winner untouched", cmp_val, 110);
  endtask

  task automatic t_none();
    do_reset();
    set_now(100);
    send(2'd0, 0, 200);
    wait_idle();
    chk(cmp_en == 1'b1, "R7 armed", cmp_en, 1);
    send(2'd2, 0, 0);
    wait_idle();
    chk(cmp_en == 1'b0, "R7 none armed", cmp_en, 0);
  endtask

  task automatic t_fire();
    do_reset();
    set_now(100);
    send(2'd1, 0, 150);
    send(2'd1, 2, 170);
    send(2'd1, 3, 300);
    send(2'd0, 1, 140);
    wait_idle();
    chk(cmp_val == 140, "R8 first compare", cmp_val, 140);
    send(2'd1, 0, 130);
    send(2'd1, 4, 124);
    send(2'd1, 5, 125);
    fire_seen = '0;
    ready_low = 0;
    set_now(140);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(fire_seen == 8'b0010_0011, "R8 batch fire tolerance", fire_seen, 8'b0010_0011);
    chk(ready_low == 1, "R12 ready low one cycle", ready_low, 1);
    chk(cmp_val == 170, "R8 reschedule after fire", cmp_val, 170);
    fire_seen = '0;
    set_now(170);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(fire_seen == 8'b0000_0100, "R8 fired slots disarmed", fire_seen, 8'b0000_0100);
    chk(cmp_val == 300, "R8 next compare", cmp_val, 300);
  endtask

  task automatic t_bad_idx();
    do_reset();
    set_now(100);
    send(2'd0, 0, 200);
    wait_idle();
    send(2'd0, 4'd8, 150);
    #1;
    chk(!busy, "R10 no scan", busy, 0);
    chk(cmp_val == 200, "R10 cmp held", cmp_val, 200);
    send(2'd1, 4'd9, 120);
    send(2'd0, 0, 200);
    wait_idle();
    chk(cmp_val == 200, "R10 no slot written", cmp_val, 200);
  endtask

  task automatic t_during_scan();
    do_reset();
    set_now(100);
    send(2'd0, 0, 500);
    send(2'd0, 1, 300);
    wait_idle();
    chk(cmp_val == 300, "R11 write in scan", cmp_val, 300);
    send(2'd0, 2, 400);
    send(2'd2, 1, 0);
    wait_idle();
    chk(cmp_val == 400, "R11 disarm in scan", cmp_val, 400);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_nearest_and_quiet();
    t_wrap();
    t_lookback();
    t_clamp();
    t_same();
    t_none();
    t_fire();
    t_bad_idx();
    t_during_scan();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule